// File: doc/BRIEF.md
# OBI to fixed-latency memory bridge

This block sits between an OBI manager, typically the read/write backend of a DMA engine, and one port of a tightly coupled banked memory. It passes address, write enable, byte enables and write data straight through to the memory port. The memory answers reads a fixed number of cycles after it grants them and gives no answer at all for writes. The OBI side, however, expects one R-channel response for every accepted request.

To close that gap, the bridge puts every granted request into a tracking pipeline whose depth equals the memory latency. Each slot carries the request ID and a flag saying whether the request was a write. When a slot leaves the pipeline, the bridge emits a response. A read response carries the memory data. A write response carries zero data. Both carry the original ID.

A single-entry hold register keeps a response while the manager holds R-ready low. The bridge grants a new request only if its response cannot find the hold register already full. This stops back-to-back requests from overwriting a pending response and leaving the manager stalled.

Top module: `obi_mem_bridge`

## Requirements
- R1: After reset is released, with no request pending, `obi_rvalid_o`, `obi_gnt_o` and `mem_req_o` are all 0.
- R2: `mem_req_o` is asserted only while `obi_req_i` is high and the bridge can accept a request. `obi_gnt_o` is high exactly when `mem_req_o` and `mem_gnt_i` are both high. With `mem_gnt_i` low, no request is granted.
- R3: While `mem_req_o` is high, `mem_addr_o`, `mem_we_o` (1 = write), `mem_be_o` and `mem_wdata_o` equal the matching OBI A-channel inputs.
- R4: A granted read (`obi_we_i` = 0) is first presented on `obi_rvalid_o` exactly MEM_LAT cycles after its grant cycle. Its `obi_rdata_o` is the value `mem_rdata_i` held in that cycle, and its `obi_rid_o` is the request's `obi_aid_i`.
- R5: A granted write (`obi_we_i` = 1) is first presented on `obi_rvalid_o` exactly MEM_LAT cycles after its grant cycle, with `obi_rdata_o` = 0 and `obi_rid_o` equal to the request's `obi_aid_i`.
- R6: While `obi_rvalid_o` is high and `obi_rready_i` is low, the response stays valid and its ID and data stay unchanged in the next cycle.
- R7: In any cycle where `obi_rvalid_o` is high and `obi_rready_i` is low, `obi_gnt_o` is 0. A grant is given only when no unconsumed response would remain outstanding besides the new one.
- R8: With MEM_LAT = 1, `obi_rready_i` held high and `mem_gnt_i` held high, a continuous request stream is granted in every cycle, and responses follow in consecutive cycles.
- R9: Every granted request receives exactly one response, in grant order. `obi_err_o` is always 0, and no response appears without a granted request before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| obi_req_i | input | 1 | OBI A-channel request |
| obi_gnt_o | output | 1 | OBI A-channel grant |
| obi_addr_i | input | ADDR_W | Request address |
| obi_we_i | input | 1 | 1 = write, 0 = read |
| obi_be_i | input | DATA_W/8 | Byte enables |
| obi_wdata_i | input | DATA_W | Write data |
| obi_aid_i | input | ID_W | Request ID |
| obi_rvalid_o | output | 1 | Response valid |
| obi_rready_i | input | 1 | Manager ready for a response |
| obi_rdata_o | output | DATA_W | Read data (0 for writes) |
| obi_rid_o | output | ID_W | Response ID |
| obi_err_o | output | 1 | Error flag, always 0 |
| mem_req_o | output | 1 | Memory request |
| mem_gnt_i | input | 1 | Memory grant |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_be_o | output | DATA_W/8 | Memory byte enables |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid MEM_LAT cycles after grant |

## Verification
Grant, memory request and the forwarded A-channel fields are combinational results of the current inputs. The bench therefore checks them in the same cycle it drives them, sampling just after the inputs settle at mid-cycle. Every grant is logged with its cycle number, and each response must first show up exactly MEM_LAT cycles after that cycle, whether the manager then takes it or stalls. The memory model registers its read data once, so the data is valid in that same cycle. Stability while stalled is compared between consecutive mid-cycle samples, and the count of outstanding responses is checked to be zero after a drain period with R-ready high.

// File: rtl/obi_mem_bridge_pkg.sv
package obi_mem_bridge_pkg;

  typedef enum logic {
    SRC_PIPE = 1'b0,
    SRC_HOLD = 1'b1
  } rsp_src_e;

endpackage

// File: rtl/obi_mem_bridge_track.sv
module obi_mem_bridge_track #(
  parameter int unsigned LAT  = 1,
  parameter int unsigned ID_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            push_we_i,
  input  logic [ID_W-1:0] push_id_i,
  output logic            pop_valid_o,
  output logic            pop_we_o,
  output logic [ID_W-1:0] pop_id_o
);

  logic            v_q  [LAT];
  logic            we_q [LAT];
  logic [ID_W-1:0] id_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q[0]  <= 1'b0;
      we_q[0] <= 1'b0;
      id_q[0] <= '0;
    end else begin
      v_q[0]  <= push_i;
      we_q[0] <= push_we_i;
      id_q[0] <= push_id_i;
    end
  end

  for (genvar k = 1; k < LAT; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[k]  <= 1'b0;
        we_q[k] <= 1'b0;
        id_q[k] <= '0;
      end else begin
        v_q[k]  <= v_q[k-1];
        we_q[k] <= we_q[k-1];
        id_q[k] <= id_q[k-1];
      end
    end
  end

  assign pop_valid_o = v_q[LAT-1];
  assign pop_we_o    = we_q[LAT-1];
  assign pop_id_o    = id_q[LAT-1];

endmodule

// File: rtl/obi_mem_bridge_hold.sv
module obi_mem_bridge_hold
  import obi_mem_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              emerge_valid_i,
  input  logic              emerge_we_i,
  input  logic [ID_W-1:0]   emerge_id_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              rready_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ID_W-1:0]   rid_o,
  output logic              fire_o
);

  logic              hold_v_q;
  logic              hold_we_q;
  logic [ID_W-1:0]   hold_id_q;
  logic [DATA_W-1:0] hold_data_q;
  logic [DATA_W-1:0] emerge_data;
  logic              load;
  logic              hold_v_d;
  rsp_src_e          src;

  assign emerge_data = emerge_we_i ? '0 : mem_rdata_i;
  assign src         = hold_v_q ? SRC_HOLD : SRC_PIPE;

  // held entry always drains before a newer one
  always_comb begin
    unique case (src)
      SRC_HOLD: begin
        rdata_o = hold_data_q;
        rid_o   = hold_id_q;
      end
      default: begin
        rdata_o = emerge_data;
        rid_o   = emerge_id_i;
      end
    endcase
  end

  assign rvalid_o = hold_v_q | emerge_valid_i;
  assign fire_o   = rvalid_o & rready_i;

  assign load     = emerge_valid_i & (hold_v_q ? rready_i : ~rready_i);
  assign hold_v_d = hold_v_q ? (rready_i ? emerge_valid_i : 1'b1)
                             : (emerge_valid_i & ~rready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q    <= 1'b0;
      hold_we_q   <= 1'b0;
      hold_id_q   <= '0;
      hold_data_q <= '0;
    end else begin
      hold_v_q <= hold_v_d;
      if (load) begin
        hold_we_q   <= emerge_we_i;
        hold_id_q   <= emerge_id_i;
        hold_data_q <= emerge_data;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hold_v_q && !rready_i && emerge_valid_i)); // R7

  AST_RSP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rid_o) && $stable(rdata_o))); // R6

  AST_HELD_WR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_v_q && hold_we_q) |-> (rdata_o == '0)); // R5

endmodule

// File: rtl/obi_mem_bridge_admit.sv
module obi_mem_bridge_admit #(
  parameter int unsigned LAT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic fire_i,
  output logic accept_o,
  output logic busy_o
);

  localparam int unsigned CW = $clog2(LAT + 2);

  logic [CW-1:0] occ_q;

  // at most one unconsumed response may exist once the cycle ends
  assign accept_o = (occ_q == CW'(0)) || ((occ_q == CW'(1)) && fire_i);
  assign busy_o   = (occ_q != CW'(0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_q + CW'(grant_i) - CW'(fire_i);
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> busy_o); // R9

endmodule

// File: rtl/obi_mem_bridge.sv
module obi_mem_bridge #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ID_W    = 4,
  parameter int unsigned MEM_LAT = 1,
  localparam int unsigned BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              obi_req_i,
  output logic              obi_gnt_o,
  input  logic [ADDR_W-1:0] obi_addr_i,
  input  logic              obi_we_i,
  input  logic [BE_W-1:0]   obi_be_i,
  input  logic [DATA_W-1:0] obi_wdata_i,
  input  logic [ID_W-1:0]   obi_aid_i,
  output logic              obi_rvalid_o,
  input  logic              obi_rready_i,
  output logic [DATA_W-1:0] obi_rdata_o,
  output logic [ID_W-1:0]   obi_rid_o,
  output logic              obi_err_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  logic            accept;
  logic            busy;
  logic            fire;
  logic            pop_valid;
  logic            pop_we;
  logic [ID_W-1:0] pop_id;

  assign mem_req_o   = obi_req_i & accept;
  assign obi_gnt_o   = mem_req_o & mem_gnt_i;
  assign mem_addr_o  = obi_addr_i;
  assign mem_we_o    = obi_we_i;
  assign mem_be_o    = obi_be_i;
  assign mem_wdata_o = obi_wdata_i;
  assign obi_err_o   = 1'b0;

  obi_mem_bridge_admit #(
    .LAT (MEM_LAT)
  ) i_admit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .grant_i  (obi_gnt_o),
    .fire_i   (fire),
    .accept_o (accept),
    .busy_o   (busy)
  );

  obi_mem_bridge_track #(
    .LAT  (MEM_LAT),
    .ID_W (ID_W)
  ) i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (obi_gnt_o),
    .push_we_i   (obi_we_i),
    .push_id_i   (obi_aid_i),
    .pop_valid_o (pop_valid),
    .pop_we_o    (pop_we),
    .pop_id_o    (pop_id)
  );

  obi_mem_bridge_hold #(
    .DATA_W (DATA_W),
    .ID_W   (ID_W)
  ) i_hold (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .emerge_valid_i (pop_valid),
    .emerge_we_i    (pop_we),
    .emerge_id_i    (pop_id),
    .mem_rdata_i    (mem_rdata_i),
    .rready_i       (obi_rready_i),
    .rvalid_o       (obi_rvalid_o),
    .rdata_o        (obi_rdata_o),
    .rid_o          (obi_rid_o),
    .fire_o         (fire)
  );

  AST_GNT_NEEDS_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obi_gnt_o |-> (mem_gnt_i && obi_req_i)); // R2

  AST_NO_GNT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obi_rvalid_o && !obi_rready_i) |-> !obi_gnt_o); // R7

  AST_RSP_HAS_TXN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obi_rvalid_o |-> busy); // R9

  AST_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !obi_err_o); // R9

endmodule

// File: tb/test_obi_mem_bridge.sv
`timescale 1ns/100ps
module test_obi_mem_bridge;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ID_W   = 4;
  localparam int unsigned LAT    = 1;
  localparam int unsigned BE_W   = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, gnt;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [BE_W-1:0]   be = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [ID_W-1:0]   aid = '0;
  logic              rvalid, rready = 1'b1, err;
  logic [DATA_W-1:0] rdata;
  logic [ID_W-1:0]   rid;
  logic              mreq, mgnt = 1'b1, mwe;
  logic [ADDR_W-1:0] maddr;
  logic [BE_W-1:0]   mbe;
  logic [DATA_W-1:0] mwdata;
  logic [DATA_W-1:0] mrdata = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  obi_mem_bridge #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MEM_LAT(LAT)
  ) i_obi_mem_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .obi_req_i(req), .obi_gnt_o(gnt), .obi_addr_i(addr), .obi_we_i(we),
    .obi_be_i(be), .obi_wdata_i(wdata), .obi_aid_i(aid),
    .obi_rvalid_o(rvalid), .obi_rready_i(rready), .obi_rdata_o(rdata),
    .obi_rid_o(rid), .obi_err_o(err),
    .mem_req_o(mreq), .mem_gnt_i(mgnt), .mem_addr_o(maddr), .mem_we_o(mwe),
    .mem_be_o(mbe), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  task automatic check(input bit ok, input string req_tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req_tag, act, exp, cyc);
    end
  endtask

  // memory model and scoreboard
  logic [DATA_W-1:0] mem [64];
  logic [DATA_W-1:0] pend_rdata = '0;
  logic [ID_W-1:0]   q_id [$];
  logic [DATA_W-1:0] q_data [$];
  int                q_cyc [$];
  bit                presented = 0;
  logic              p_stall = 0;
  logic [ID_W-1:0]   p_rid;
  logic [DATA_W-1:0] p_rdata;

  initial for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 | i;

  always @(posedge clk) mrdata <= pend_rdata;

  always begin
    @(negedge clk);
    #1;
    cyc++;
    if (rst_n && !done) begin
      if (p_stall) begin
        check(rvalid == 1'b1, "R6 valid held", 64'(rvalid), 64'd1);
        check(rid == p_rid && rdata == p_rdata, "R6 payload held", 64'(rdata), 64'(p_rdata));
      end
      if (rvalid && !rready)
        check(gnt == 1'b0, "R7 no grant while stalled", 64'(gnt), 64'd0);
      check(gnt == (mreq && mgnt), "R2 grant", 64'(gnt), 64'(mreq && mgnt));
      check(err == 1'b0, "R9 err", 64'(err), 64'd0);
      if (rvalid) begin
        if (q_id.size() == 0) begin
          check(1'b0, "R9 spurious response", 64'(rid), 64'd0);
        end else begin
          if (!presented) begin
            check(cyc == q_cyc[0] + LAT, "R4 R5 latency", 64'(cyc), 64'(q_cyc[0] + LAT));
            presented = 1;
          end
          check(rid == q_id[0], "R4 R5 R9 id order", 64'(rid), 64'(q_id[0]));
          check(rdata == q_data[0], "R4 R5 data", 64'(rdata), 64'(q_data[0]));
          if (rready) begin
            void'(q_id.pop_front());
            void'(q_data.pop_front());
            void'(q_cyc.pop_front());
            presented = 0;
          end
        end
      end
      if (gnt) begin
        q_id.push_back(aid);
        q_cyc.push_back(cyc);
        if (we) begin
          for (int b = 0; b < BE_W; b++)
            if (be[b]) mem[addr[7:2]][b*8 +: 8] = wdata[b*8 +: 8];
          q_data.push_back('0);
        end else begin
          pend_rdata = mem[addr[7:2]];
          q_data.push_back(mem[addr[7:2]]);
        end
      end
      p_stall = rvalid && !rready;
      p_rid   = rid;
      p_rdata = rdata;
    end
  end

  task automatic issue(input logic w, input logic [7:0] a, input logic [DATA_W-1:0] d,
                       input logic [BE_W-1:0] e, input logic [ID_W-1:0] i);
    @(negedge clk);
    req = 1'b1; we = w; addr = {24'h0, a}; wdata = d; be = e; aid = i;
    #1;
    while (!gnt) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req = 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    check(rvalid == 1'b0, "R1 rvalid", 64'(rvalid), 64'd0);
    check(gnt == 1'b0, "R1 gnt", 64'(gnt), 64'd0);
    check(mreq == 1'b0, "R1 mem_req", 64'(mreq), 64'd0);
  endtask

  task automatic t_forward();
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 32'h0000_0014; wdata = 32'hDEAD_BEEF; be = 4'b1011; aid = 4'h3;
    #1;
    check(mreq == 1'b1, "R2 mem_req", 64'(mreq), 64'd1);
    check(maddr == addr, "R3 addr", 64'(maddr), 64'(addr));
    check(mwe == 1'b1, "R3 we", 64'(mwe), 64'd1);
    check(mbe == 4'b1011, "R3 be", 64'(mbe), 64'hB);
    check(mwdata == 32'hDEAD_BEEF, "R3 wdata", 64'(mwdata), 64'hDEAD_BEEF);
    idle(3);
  endtask

  task automatic t_mem_stall();
    mgnt = 1'b0;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 32'h8; aid = 4'h5;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(gnt == 1'b0, "R2 no grant without mem_gnt", 64'(gnt), 64'd0);
      @(negedge clk);
    end
    mgnt = 1'b1;
    #1;
    check(gnt == 1'b1, "R2 grant with mem_gnt", 64'(gnt), 64'd1);
    idle(3);
  endtask

  task automatic t_write_read();
    issue(1'b1, 8'h20, 32'h1234_5678, 4'hF, 4'h1);
    issue(1'b1, 8'h24, 32'hCAFE_F00D, 4'h3, 4'h2);
    issue(1'b0, 8'h20, '0, 4'hF, 4'h3);
    issue(1'b0, 8'h24, '0, 4'hF, 4'h4);
    idle(4);
  endtask

  task automatic t_back_to_back();
    int granted = 0;
    @(negedge clk);
    req = 1'b1; we = 1'b0; be = 4'hF;
    for (int k = 0; k < 8; k++) begin
      addr = 32'(k * 4); aid = 4'(k);
      #1;
      if (gnt) granted++;
      @(negedge clk);
    end
    req = 1'b0;
    check(granted == 8, "R8 grant every cycle", 64'(granted), 64'd8);
    idle(4);
  endtask

  task automatic t_stall();
    rready = 1'b0;
    issue(1'b0, 8'h30, '0, 4'hF, 4'h9);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 32'h34; wdata = 32'h7; be = 4'hF; aid = 4'hA;
    for (int k = 0; k < 4; k++) begin
      #1;
      check(gnt == 1'b0, "R7 stalled grant", 64'(gnt), 64'd0);
      check(rvalid == 1'b1, "R6 pending", 64'(rvalid), 64'd1);
      @(negedge clk);
    end
    rready = 1'b1;
    #1;
    check(gnt == 1'b1, "R7 grant after drain", 64'(gnt), 64'd1);
    @(negedge clk);
    req = 1'b0;
    rready = 1'b0;
    idle(3);
    rready = 1'b1;
    idle(3);
  endtask

  task automatic t_random();
    bit keep = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      rready = ($urandom_range(0, 3) != 0);
      mgnt   = ($urandom_range(0, 4) != 0);
      if (!keep) begin
        req   = $urandom_range(0, 1);
        we    = $urandom_range(0, 1);
        addr  = {24'h0, 6'($urandom_range(0, 63)), 2'b00};
        wdata = $urandom;
        be    = 4'($urandom_range(1, 15));
        aid   = 4'($urandom);
      end
      #1;
      keep = req && !gnt;
    end
    rready = 1'b1;
    mgnt = 1'b1;
    idle(10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_forward();
    t_mem_stall();
    t_write_read();
    t_back_to_back();
    t_stall();
    t_random();
    check(q_id.size() == 0, "R9 all responded", 64'(q_id.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule